// File: doc/BRIEF.md
# Scan Pattern Density Sorter

This block takes scan test patterns one at a time and sorts each one by how much of it is actually specified. A pattern is a fixed-length ternary vector in which each position holds 0, 1 or don't-care, with two bits per position. The block counts the don't-care positions and forms the fraction of specified positions. It then compares that fraction with a threshold supplied as a numerator and denominator.

A sparse pattern, whose specified fraction is at or below the threshold, is sent to the compression output. A dense pattern goes to the bypass output without any change. Both outputs use a valid/ready handshake. The result appears one cycle after the input is accepted. The comparison uses cross-multiplication, so no divider is needed. A zero denominator selects the built-in default threshold of 1/5.

Top module: `scan_density_sorter`

## Requirements
- R1: Position i of a pattern is held in bits [2i+1:2i]. Code 00 means 0 and code 01 means 1. Codes 10 and 11 both mean don't-care.
- R2: Let s be the number of specified positions and L the pattern length (default 19). A pattern goes to the compression output when s*den <= num*L. Otherwise it goes to the bypass output.
- R3: When thr_den is 0, the threshold used is DEF_NUM/DEF_DEN (default 1/5), and thr_num is ignored.
- R4: Each accepted pattern makes exactly one of byp_valid and cmp_valid high. This happens in the cycle after the acceptance edge. The two valids are never high together.
- R5: The pattern presented on the selected output is bit-for-bit the accepted input pattern.
- R6: A presented pattern stays valid and unchanged until its own ready is high. While it waits, in_ready is low, and the other path's ready has no effect.
- R7: After reset both output valids are low and in_ready is high.
- R8: The threshold is sampled when the pattern is accepted. Changing thr_num or thr_den afterwards does not move a pattern that is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pattern valid |
| in_ready | output | 1 | Block can accept a pattern |
| in_pat | input | 2*PAT_LEN | Ternary pattern, two bits per position |
| thr_num | input | TW | Threshold numerator |
| thr_den | input | TW | Threshold denominator; 0 selects the default |
| byp_valid | output | 1 | Dense pattern available |
| byp_ready | input | 1 | Bypass consumer ready |
| byp_pat | output | 2*PAT_LEN | Dense pattern, unchanged |
| cmp_valid | output | 1 | Sparse pattern available |
| cmp_ready | input | 1 | Compression consumer ready |
| cmp_pat | output | 2*PAT_LEN | Sparse pattern, unchanged |

## Verification
The assertions check several things on every cycle:
- the two output valids are never high together;
- a stalled output holds both its valid and its pattern;
- each accepted pattern appears on one path in the following cycle with its bits intact.

Only the bench's scenarios can show whether the chosen path is the right one. The bench sweeps every specified-position count against several thresholds, including the zero-denominator default and thresholds at or above one. It also shows that a threshold change during a stall has no effect.

// File: rtl/scan_density_sorter.sv
module scan_density_sorter #(
  parameter int PAT_LEN = 19,
  parameter int TW      = 8,
  parameter int DEF_NUM = 1,
  parameter int DEF_DEN = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2*PAT_LEN-1:0] in_pat,
  input  logic [TW-1:0]        thr_num,
  input  logic [TW-1:0]        thr_den,
  output logic                 byp_valid,
  input  logic                 byp_ready,
  output logic [2*PAT_LEN-1:0] byp_pat,
  output logic                 cmp_valid,
  input  logic                 cmp_ready,
  output logic [2*PAT_LEN-1:0] cmp_pat
);
  localparam int CW = $clog2(PAT_LEN + 1);
  localparam int PW = TW + CW;

  logic [CW-1:0]        x_cnt, spec_cnt;
  logic [TW-1:0]        num_eff, den_eff;
  logic [PW-1:0]        lhs, rhs;
  logic                 sparse;
  logic                 hold_v, hold_sparse;
  logic [2*PAT_LEN-1:0] hold_pat;
  logic                 drain, take;

  always_comb begin
    x_cnt = '0;
    for (int i = 0; i < PAT_LEN; i++)
      x_cnt = x_cnt + CW'(in_pat[2*i+1]);
  end

  assign spec_cnt = CW'(PAT_LEN) - x_cnt;
  assign num_eff  = (thr_den == '0) ? TW'(DEF_NUM) : thr_num;
  assign den_eff  = (thr_den == '0) ? TW'(DEF_DEN) : thr_den;
  assign lhs      = PW'(spec_cnt) * PW'(den_eff);
  assign rhs      = PW'(num_eff) * PW'(PAT_LEN);
  assign sparse   = (lhs <= rhs);

  assign byp_valid = hold_v & ~hold_sparse;
  assign cmp_valid = hold_v & hold_sparse;
  assign byp_pat   = hold_pat;
  assign cmp_pat   = hold_pat;
  assign drain     = (byp_valid & byp_ready) | (cmp_valid & cmp_ready);
  assign in_ready  = ~hold_v | drain;
  assign take      = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v      <= 1'b0;
      hold_sparse <= 1'b0;
      hold_pat    <= '0;
    end else if (take) begin
      hold_v      <= 1'b1;
      hold_sparse <= sparse;
      hold_pat    <= in_pat;
    end else if (drain) begin
      hold_v      <= 1'b0;
    end
  end

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !(byp_valid && cmp_valid)); // R4
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (byp_valid || cmp_valid)); // R4
  AST_PAT_INTACT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((byp_valid ? byp_pat : cmp_pat) == $past(in_pat))); // R5
  AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_valid && !byp_ready) |=> (byp_valid && $stable(byp_pat))); // R6
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_ready) |=> (cmp_valid && $stable(cmp_pat))); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((byp_valid && !byp_ready) || (cmp_valid && !cmp_ready)) |-> !in_ready); // R6
endmodule

// File: tb/sim_scan_density_sorter.sv
module sim_scan_density_sorter;
  localparam int L = 19;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2*L-1:0] in_pat = '0, byp_pat, cmp_pat;
  logic [7:0] thr_num = '0, thr_den = '0;
  logic byp_valid, byp_ready = 1'b1, cmp_valid, cmp_ready = 1'b1;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  scan_density_sorter u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pat(in_pat), .thr_num(thr_num), .thr_den(thr_den), .byp_valid(byp_valid),
    .byp_ready(byp_ready), .byp_pat(byp_pat), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_pat(cmp_pat));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1: s specified positions (codes 00/01), the rest coded 10 or 11
  function automatic logic [2*L-1:0] mk(input int s, input int off);
    logic [2*L-1:0] p = '0;
    for (int i = 0; i < L; i++) begin
      if (((i * 7 + off) % L) < s) p[2*i +: 2] = {1'b0, 1'(i + off)};
      else                         p[2*i +: 2] = {1'b1, 1'(i)};
    end
    return p;
  endfunction

  task automatic send(input int s, input int n, input int d, input int off);
    logic [2*L-1:0] p = mk(s, off);
    int ne = (d == 0) ? 1 : n;
    int de = (d == 0) ? 5 : d;
    logic exp_cmp = (s * de <= ne * L);
    @(negedge clk);
    in_valid = 1'b1; in_pat = p; thr_num = 8'(n); thr_den = 8'(d);
    chk("R6 in_ready", 64'(in_ready), 64'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk(d == 0 ? "R3 path" : "R2 path", 64'(cmp_valid), 64'(exp_cmp));
    chk("R4 one valid", 64'(byp_valid ^ cmp_valid), 64'(1));
    chk("R5 pattern", 64'(exp_cmp ? cmp_pat : byp_pat), 64'(p));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int tn[7] = '{0, 1, 0, 1, 3, 4, 9};
    int td[7] = '{0, 5, 4, 2, 4, 4, 4};
    repeat (3) @(negedge clk);
    chk("R7 byp_valid", 64'(byp_valid), 64'(0));
    chk("R7 cmp_valid", 64'(cmp_valid), 64'(0));
    chk("R7 in_ready", 64'(in_ready), 64'(1));
    rst_n = 1'b1;
    for (int t = 0; t < 7; t++)
      for (int s = 0; s <= L; s++)
        send(s, tn[t], td[t], t + s);
    // R3: thr_num ignored when den is 0; s=3 sparse, s=4 dense
    send(3, 200, 0, 1);
    send(4, 200, 0, 2);

    // R6/R8: sparse pattern stalled, other ready toggled, threshold changed
    cmp_ready = 1'b0;
    send(2, 0, 0, 3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      thr_num = 8'd0; thr_den = 8'd1; byp_ready = 1'(k);
      chk("R6 cmp held", 64'(cmp_valid), 64'(1));
      chk("R8 no byp", 64'(byp_valid), 64'(0));
      chk("R6 pat stable", 64'(cmp_pat), 64'(mk(2, 3)));
      chk("R6 in_ready low", 64'(in_ready), 64'(0));
    end
    cmp_ready = 1'b1; byp_ready = 1'b1;
    @(negedge clk);
    chk("R6 drained", 64'(cmp_valid), 64'(0));

    // R6/R8: dense pattern stalled, threshold raised to all-sparse
    byp_ready = 1'b0;
    send(10, 0, 0, 4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      thr_num = 8'd9; thr_den = 8'd4; cmp_ready = 1'(k);
      chk("R8 stays byp", 64'(byp_valid), 64'(1));
      chk("R6 no cmp", 64'(cmp_valid), 64'(0));
      chk("R6 pat stable", 64'(byp_pat), 64'(mk(10, 4)));
    end
    byp_ready = 1'b1; cmp_ready = 1'b1;
    @(negedge clk);
    chk("R6 drained", 64'(byp_valid), 64'(0));
    chk("R7 idle ready", 64'(in_ready), 64'(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule